// File: doc/BRIEF.md
# Single-Bus ALU Datapath

This block runs one three-register ALU instruction through a datapath that has a single shared internal bus. It holds thirty-two 32-bit general registers, a Y staging register in front of a combinational ALU, and a Z register after it. Every bus transfer has exactly one source, so one operation takes three transfer steps.

In the first step the second source register goes onto the bus and Y captures it. In the second step the first source register goes onto the bus, and Z captures the ALU result formed from the bus and Y. In the third step Z goes onto the bus and the destination register captures it.

A one-cycle start pulse captures the opcode and the three register numbers. A one-hot sequencer then steps through the transfers and raises a done flag for one cycle. A combinational debug read port shows any register at any time.

Top module: `bus_xfer_datapath`

## Requirements
- R1: While reset is low and after it is released, every register reads zero on the debug port, done is low and the sequencer is idle.
- R2: A start pulse seen while idle captures op, ra, rb and rc at that edge. Later changes on those inputs have no effect on the running operation.
- R3: Exactly one bus source is active in each step, in the order: second source (rc), then first source (rb), then Z. The operand order is visible in subtraction, where the result is R[rb] minus R[rc].
- R4: Done is high for exactly one cycle. That cycle starts at the third rising edge after the edge that sampled start. The destination register shows its new value in the same cycle.
- R5: Opcode 12 writes R[rb]+R[rc] and opcode 13 writes R[rb]-R[rc], both two's complement and modulo 2^32.
- R6: Opcode 14 writes R[rb] AND R[rc] and opcode 15 writes R[rb] OR R[rc].
- R7: Opcode 16 writes the two's complement negation of R[rc] and opcode 17 writes the bitwise inverse of R[rc]. In both, rb has no effect on the result.
- R8: Any other 5-bit opcode writes R[rb] unchanged into R[ra].
- R9: A start pulse is ignored while an operation is under way, including during the done cycle. No extra done appears and no register changes because of it.
- R10: The debug port shows R[rd_addr] combinationally, and only the destination register of a finished operation changes.
- R11: The destination may equal either source. Operands are the register values from before the write, so R[a]=R[a]+R[a] doubles R[a].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to run the instruction on op/ra/rb/rc |
| op | input | 5 | Operation code |
| ra | input | 5 | Destination register number |
| rb | input | 5 | First source register number |
| rc | input | 5 | Second source register number |
| rd_addr | input | 5 | Debug read register number |
| done | output | 1 | One-cycle completion flag |
| rd_data | output | 32 | Contents of the register chosen by rd_addr |

## Verification
If start is sampled at edge k, the design gates rc after k, gates rb after k+1 and gates Z after k+2. The destination register and done both change at edge k+3, and done clears at edge k+4. The bench's behavioural model advances through the same edge count and applies its write at the same edge. Done and the debug read value are compared against the model at every falling clock edge, halfway between the edges where the design changes. Each directed operation also counts falling edges from the start edge and requires done on exactly the fourth.

// File: rtl/bus_xfer_datapath.sv
module bus_xfer_datapath #(
  parameter int DW   = 32,
  parameter int NREG = 32,
  parameter int OPW  = 5,
  parameter int AW   = $clog2(NREG)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [OPW-1:0] op,
  input  logic [AW-1:0]  ra,
  input  logic [AW-1:0]  rb,
  input  logic [AW-1:0]  rc,
  input  logic [AW-1:0]  rd_addr,
  output logic           done,
  output logic [DW-1:0]  rd_data
);
  localparam logic [OPW-1:0] OP_ADD = OPW'(12);
  localparam logic [OPW-1:0] OP_SUB = OPW'(13);
  localparam logic [OPW-1:0] OP_AND = OPW'(14);
  localparam logic [OPW-1:0] OP_OR  = OPW'(15);
  localparam logic [OPW-1:0] OP_NEG = OPW'(16);
  localparam logic [OPW-1:0] OP_NOT = OPW'(17);

  typedef enum logic [4:0] {
    ST_IDLE = 5'b00001,
    ST_GRC  = 5'b00010,
    ST_GRB  = 5'b00100,
    ST_GZ   = 5'b01000,
    ST_FIN  = 5'b10000
  } step_t;

  step_t state, state_nx;

  logic [OPW-1:0] op_q;
  logic [AW-1:0]  ra_q, rb_q, rc_q;
  logic [DW-1:0]  regs [NREG];
  logic [DW-1:0]  y_q, z_q, bus, alu;
  logic           gate_rc, gate_rb, gate_z, idle;

  assign idle    = (state == ST_IDLE);
  assign gate_rc = (state == ST_GRC);
  assign gate_rb = (state == ST_GRB);
  assign gate_z  = (state == ST_GZ);
  assign done    = (state == ST_FIN);

  assign bus = gate_rc ? regs[rc_q] :
               gate_rb ? regs[rb_q] :
               gate_z  ? z_q        : '0;

  always_comb begin
    unique case (state)
      ST_IDLE: state_nx = start ? ST_GRC : ST_IDLE;
      ST_GRC:  state_nx = ST_GRB;
      ST_GRB:  state_nx = ST_GZ;
      ST_GZ:   state_nx = ST_FIN;
      default: state_nx = ST_IDLE;
    endcase
  end

  always_comb begin
    case (op_q)
      OP_ADD:  alu = bus + y_q;
      OP_SUB:  alu = bus - y_q;
      OP_AND:  alu = bus & y_q;
      OP_OR:   alu = bus | y_q;
      OP_NEG:  alu = -y_q;
      OP_NOT:  alu = ~y_q;
      default: alu = bus;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      op_q  <= '0;
      ra_q  <= '0;
      rb_q  <= '0;
      rc_q  <= '0;
      y_q   <= '0;
      z_q   <= '0;
    end else begin
      state <= state_nx;
      if (idle && start) begin
        op_q <= op;
        ra_q <= ra;
        rb_q <= rb;
        rc_q <= rc;
      end
      if (gate_rc) y_q <= bus;
      if (gate_rb) z_q <= alu;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (gate_z) begin
      regs[ra_q] <= bus;
    end
  end

  assign rd_data = regs[rd_addr];
endmodule

// File: rtl/bus_xfer_checker.sv
module bus_xfer_checker #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          done,
  input logic [4:0]    state,
  input logic          gate_rc,
  input logic          gate_rb,
  input logic          gate_z,
  input logic [DW-1:0] bus,
  input logic [DW-1:0] y_q
);
  // R1
  step_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(state));

  // R3
  one_driver_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({gate_rc, gate_rb, gate_z}));

  // R3
  rc_then_rb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gate_rc |=> gate_rb);

  // R3
  rb_then_z_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gate_rb |=> gate_z);

  // R4
  done_after_z_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gate_z |=> done);

  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R2
  launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && state == 5'b00001) |=> gate_rc);

  // R9
  no_relaunch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_rc || gate_rb || gate_z || done) |=> !gate_rc);

  // R11
  y_holds_rc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gate_rb |-> y_q == $past(bus));
endmodule

bind bus_xfer_datapath bus_xfer_checker #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .done(done), .state(state),
  .gate_rc(gate_rc), .gate_rb(gate_rb), .gate_z(gate_z), .bus(bus), .y_q(y_q)
);

// File: tb/bus_xfer_datapath_bench.sv
`timescale 1ns/1ps
module bus_xfer_datapath_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [4:0]  op = '0, ra = '0, rb = '0, rc = '0, rd_addr = '0;
  logic        done;
  logic [31:0] rd_data;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  bus_xfer_datapath u_bus_xfer_datapath (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .ra(ra), .rb(rb),
    .rc(rc), .rd_addr(rd_addr), .done(done), .rd_data(rd_data)
  );

  function automatic logic [31:0] alu_ref(input logic [4:0] o,
                                          input logic [31:0] b, input logic [31:0] c);
    case (o)
      5'd12:   return b + c;
      5'd13:   return b - c;
      5'd14:   return b & c;
      5'd15:   return b | c;
      5'd16:   return 32'd0 - c;
      5'd17:   return ~c;
      default: return b;
    endcase
  endfunction

  logic [31:0] mdl [32];
  int          phase;
  logic [4:0]  m_op, m_ra, m_rb, m_rc;

  always @(posedge clk) begin
    if (!rst_n) begin
      phase = 0;
      for (int i = 0; i < 32; i++) mdl[i] = '0;
    end else begin
      case (phase)
        0: if (start) begin
             m_op = op; m_ra = ra; m_rb = rb; m_rc = rc;
             phase = 1;
           end
        1: phase = 2;
        2: phase = 3;
        3: begin
             mdl[m_ra] = alu_ref(m_op, mdl[m_rb], mdl[m_rc]);
             phase = 4;
           end
        default: phase = 0;
      endcase
    end
  end

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk(done == (phase == 4), "R4 done timing", 32'(done), 32'(phase == 4));
      chk(rd_data == mdl[rd_addr], "R10 debug port", rd_data, mdl[rd_addr]);
    end
  end

  task automatic run_op(input logic [4:0] o, input logic [4:0] a,
                        input logic [4:0] b, input logic [4:0] c, input string tag);
    logic [31:0] exp;
    int n;
    exp = alu_ref(o, mdl[b], mdl[c]);
    @(posedge clk); #1;
    start = 1'b1; op = o; ra = a; rb = b; rc = c; rd_addr = a;
    @(posedge clk); #1;
    start = 1'b0; op = ~o; ra = ~a; rb = ~b; rc = ~c;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!done && n < 10);
    chk(n == 4, {tag, " R4 latency"}, 32'(n), 32'd4);
    chk(rd_data == exp, {tag, " R2 latched fields"}, rd_data, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 20000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] keep;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(done == 1'b0, "R1 done in reset", 32'(done), 32'd0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    for (int i = 0; i < 32; i++) begin
      rd_addr = 5'(i);
      @(negedge clk);
      chk(rd_data == 32'd0, "R1 register cleared", rd_data, 32'd0);
      chk(done == 1'b0, "R1 idle after reset", 32'(done), 32'd0);
    end

    run_op(5'd17, 5'd1, 5'd9, 5'd0, "R7 not");
    run_op(5'd16, 5'd2, 5'd1, 5'd1, "R7 neg");
    run_op(5'd12, 5'd3, 5'd2, 5'd1, "R5 add wrap");
    run_op(5'd12, 5'd4, 5'd2, 5'd2, "R5 add");
    run_op(5'd12, 5'd4, 5'd4, 5'd4, "R11 alias double");
    run_op(5'd12, 5'd4, 5'd4, 5'd2, "R11 alias src");
    run_op(5'd17, 5'd5, 5'd0, 5'd4, "R7 not value");
    run_op(5'd13, 5'd6, 5'd5, 5'd4, "R3 R5 sub order");
    run_op(5'd13, 5'd7, 5'd4, 5'd5, "R3 R5 sub reversed");
    run_op(5'd14, 5'd8, 5'd6, 5'd7, "R6 and");
    run_op(5'd15, 5'd10, 5'd6, 5'd4, "R6 or");
    run_op(5'd3, 5'd11, 5'd6, 5'd1, "R8 copy op3");
    run_op(5'd31, 5'd12, 5'd7, 5'd1, "R8 copy op31");
    run_op(5'd0, 5'd13, 5'd10, 5'd2, "R8 copy op0");
    run_op(5'd16, 5'd14, 5'd31, 5'd6, "R7 neg ignores rb");

    keep = mdl[9];
    @(posedge clk); #1;
    start = 1'b1; op = 5'd12; ra = 5'd15; rb = 5'd6; rc = 5'd7; rd_addr = 5'd9;
    @(posedge clk); #1;
    op = 5'd17; ra = 5'd9; rb = 5'd0; rc = 5'd0;
    @(posedge clk); #1;
    start = 1'b0;
    while (!done) @(negedge clk);
    #1;
    start = 1'b1; op = 5'd17; ra = 5'd9; rb = 5'd0; rc = 5'd0;
    @(posedge clk); #1;
    start = 1'b0;
    repeat (6) begin
      @(negedge clk);
      chk(done == 1'b0, "R9 no extra done", 32'(done), 32'd0);
      chk(rd_data == keep, "R9 busy start ignored", rd_data, keep);
    end
    rd_addr = 5'd15;
    @(negedge clk);
    chk(rd_data == mdl[15], "R9 first op kept", rd_data, mdl[15]);

    for (int k = 0; k < 60; k++) begin
      logic [4:0] ro;
      ro = ($urandom % 3 == 0) ? 5'($urandom) : 5'(12 + $urandom % 6);
      run_op(ro, 5'($urandom), 5'($urandom), 5'($urandom), "R10 mixed");
    end

    for (int i = 0; i < 32; i++) begin
      rd_addr = 5'(i);
      @(negedge clk);
      chk(rd_data == mdl[i], "R10 final sweep", rd_data, mdl[i]);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule